// File: doc/BRIEF.md
# Timer Input Capture Unit

This block adds input capture to a free-running timer counter. An external event pin is synchronised to the timer clock. The block then watches it for the selected kind of transition. When a transition is accepted, the current counter value is latched into one of two capture registers and a capture status flag is raised. A level interrupt follows the flag when it is enabled.

A small lock machine decides which transitions are accepted. In single mode, only the first event after re-arming is taken. In dual mode, the first two events are taken, into separate registers, so software can subtract them to measure a period or pulse width. Every later event is ignored until software writes a one to the flag's clear input. The counter, prescaler and bus decoding sit outside this block.

Top module: `icap_unit`

## Requirements
- R1: `edge_sel` chooses the accepted transitions: 0 none, 1 rising only, 2 falling only, 3 both.
- R2: Take a pin change that is first sampled at clock edge N. If it is accepted, it loads the `cnt_val` value present at edge N+2 into the target capture register.
- R3: `cap_flag` rises on the same clock edge that capture register 1 is loaded after re-arming.
- R4: With `dual_mode` = 0, the first accepted event loads `cap1`. Every later event leaves `cap1` and `cap2` unchanged while the flag stays set.
- R5: With `dual_mode` = 1, the first accepted event loads `cap1` and the second loads `cap2`. Every later event leaves both unchanged.
- R6: A cycle with `stat_clr` = 1 while `cap_flag` = 1 clears the flag and re-arms the unit. The next accepted event loads `cap1` again.
- R7: `stat_clr` = 1 while `cap_flag` = 0 leaves the flag and both capture registers unchanged.
- R8: An event whose capture edge coincides with `stat_clr` = 1 is dropped, whatever the flag state.
- R9: `irq` is high exactly when `cap_flag` = 1 and `irq_en` = 1. It is a level, not a pulse.
- R10: Synchronous reset `rst` clears `cap_flag`, `irq`, `cap1` and `cap2`, and returns the unit to the unlocked state.
- R11: A pin pulse that spans one sampling edge is seen as two transitions. In dual mode with both edges selected, `cap2 - cap1` equals the pulse width in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer functional clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_val | input | CNT_W | Current free-running counter value |
| evt_pin | input | 1 | Asynchronous external event input |
| edge_sel | input | 2 | Transition select (0 none, 1 rise, 2 fall, 3 both) |
| dual_mode | input | 1 | 0 single capture, 1 two successive captures |
| irq_en | input | 1 | Capture interrupt enable |
| stat_clr | input | 1 | Write-one-to-clear strobe for the capture flag |
| cap1 | output | CNT_W | First capture register |
| cap2 | output | CNT_W | Second capture register |
| cap_flag | output | 1 | Capture status flag |
| irq | output | 1 | Level interrupt, flag gated by enable |

## Verification
The assertions assume three things about the inputs. `evt_pin` holds each level across at least one sampling edge. `stat_clr` is a single-cycle strobe that tracks the flag. `edge_sel`, `dual_mode` and `irq_en` are quasi-static around capture edges. The bench respects all three. It changes the pin and the clear strobe only on falling clock edges, and it holds each pin level for whole cycles. It changes configuration only while the pin is quiet. A behavioural model built on a sample queue follows every clock. It covers the case where a clear and an event land on the same edge, and the case of one-cycle pulses captured on both edges.

// File: rtl/icap_pkg.sv
package icap_pkg;

   typedef enum logic [1:0] {
      EDG_NONE = 2'd0,
      EDG_RISE = 2'd1,
      EDG_FALL = 2'd2,
      EDG_BOTH = 2'd3
   } edge_sel_t;

   typedef enum logic [1:0] {
      LK_OPEN = 2'd0,
      LK_ONE  = 2'd1,
      LK_TWO  = 2'd2
   } lock_st_t;

   localparam int unsigned NUM_CAPT = 2;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pin_async,
   output logic smp_cur,
   output logic smp_prev
);
   localparam int unsigned CHAIN = STAGES + 1;

   logic [CHAIN-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("icap_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q[0] <= pin_async;
   end

   for (genvar i = 1; i < CHAIN; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) chain_q[i] <= 1'b0;
         else     chain_q[i] <= chain_q[i-1];
      end
   end

   assign smp_cur  = chain_q[STAGES-1];
   assign smp_prev = chain_q[STAGES];

endmodule

// File: rtl/icap_edge_det.sv
module icap_edge_det
   import icap_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      smp_cur,
   input  logic      smp_prev,
   input  edge_sel_t sel,
   output logic      hit
);
   logic rise, fall;

   assign rise = smp_cur & ~smp_prev;
   assign fall = ~smp_cur & smp_prev;

   always_comb begin
      unique case (sel)
         EDG_RISE: hit = rise;
         EDG_FALL: hit = fall;
         EDG_BOTH: hit = rise | fall;
         default:  hit = 1'b0;
      endcase
   end

   // R1
   hit_needs_change_chk: assert property (@(posedge clk) disable iff (rst)
      hit |-> (smp_cur != smp_prev));

endmodule

// File: rtl/icap_lock_fsm.sv
module icap_lock_fsm
   import icap_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     hit,
   input  logic     dual_mode,
   input  logic     clr_req,
   output logic     ld1,
   output logic     ld2,
   output logic     flag,
   output lock_st_t state
);
   lock_st_t st_q, st_d;
   logic     flag_q;
   logic     rearm;

   assign rearm = clr_req & flag_q;

   always_comb begin
      st_d = st_q;
      ld1  = 1'b0;
      ld2  = 1'b0;
      if (!clr_req && hit) begin
         unique case (st_q)
            LK_OPEN: begin
               ld1  = 1'b1;
               st_d = LK_ONE;
            end
            LK_ONE: begin
               if (dual_mode) begin
                  ld2  = 1'b1;
                  st_d = LK_TWO;
               end
            end
            default: st_d = st_q;
         endcase
      end
      if (rearm) st_d = LK_OPEN;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= LK_OPEN;
         flag_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (rearm)          flag_q <= 1'b0;
         else if (ld1 | ld2) flag_q <= 1'b1;
      end
   end

   assign flag  = flag_q;
   assign state = st_q;

   // R8
   clr_blocks_load_chk: assert property (@(posedge clk) disable iff (rst)
      clr_req |-> !(ld1 || ld2));

   // R5
   locked_two_dual_only_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q == LK_ONE && st_d == LK_TWO) |-> dual_mode);

endmodule

// File: rtl/icap_unit.sv
module icap_unit
   import icap_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             evt_pin,
   input  logic [1:0]       edge_sel,
   input  logic             dual_mode,
   input  logic             irq_en,
   input  logic             stat_clr,
   output logic [CNT_W-1:0] cap1,
   output logic [CNT_W-1:0] cap2,
   output logic             cap_flag,
   output logic             irq
);
   localparam int unsigned CAPT_N = NUM_CAPT;

   if (CNT_W < 1) begin : g_bad_width
      $error("icap_unit: CNT_W must be at least 1");
   end

   logic                  smp_cur, smp_prev, hit;
   logic                  ld1, ld2, flag;
   lock_st_t              lk_state;
   logic [CAPT_N-1:0]     ld_vec;
   logic [CNT_W-1:0]      cap_q [CAPT_N];

   icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .pin_async (evt_pin),
      .smp_cur   (smp_cur),
      .smp_prev  (smp_prev)
   );

   icap_edge_det u_edge (
      .clk      (clk),
      .rst      (rst),
      .smp_cur  (smp_cur),
      .smp_prev (smp_prev),
      .sel      (edge_sel_t'(edge_sel)),
      .hit      (hit)
   );

   icap_lock_fsm u_lock (
      .clk       (clk),
      .rst       (rst),
      .hit       (hit),
      .dual_mode (dual_mode),
      .clr_req   (stat_clr),
      .ld1       (ld1),
      .ld2       (ld2),
      .flag      (flag),
      .state     (lk_state)
   );

   assign ld_vec = {ld2, ld1};

   for (genvar i = 0; i < CAPT_N; i++) begin : g_capt
      always_ff @(posedge clk) begin
         if (rst)            cap_q[i] <= '0;
         else if (ld_vec[i]) cap_q[i] <= cnt_val;
      end
   end

   assign cap1     = cap_q[0];
   assign cap2     = cap_q[1];
   assign cap_flag = flag;
   assign irq      = flag & irq_en;

   // R3
   flag_with_load_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(cap_flag) |-> (cap1 == $past(cnt_val)));

   // R4
   single_ignores_chk: assert property (@(posedge clk) disable iff (rst)
      (cap_flag && !dual_mode && !stat_clr) |=> ($stable(cap1) && $stable(cap2)));

   // R5
   two_locked_chk: assert property (@(posedge clk) disable iff (rst)
      (lk_state == LK_TWO && !stat_clr) |=> ($stable(cap1) && $stable(cap2) && cap_flag));

   // R8
   clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
      stat_clr |=> ($stable(cap1) && $stable(cap2) && !cap_flag));

   // R9
   irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
      !irq_en |-> !irq);

endmodule

// File: tb/tb_icap_unit.sv
module tb_icap_unit;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] cnt_val = '0;
   logic         evt_pin = 1'b0;
   logic [1:0]   edge_sel = 2'd0;
   logic         dual_mode = 1'b0;
   logic         irq_en = 1'b0;
   logic         stat_clr = 1'b0;
   logic [W-1:0] cap1, cap2;
   logic         cap_flag, irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   icap_unit #(.CNT_W(W)) dut (
      .clk(clk), .rst(rst), .cnt_val(cnt_val), .evt_pin(evt_pin),
      .edge_sel(edge_sel), .dual_mode(dual_mode), .irq_en(irq_en),
      .stat_clr(stat_clr), .cap1(cap1), .cap2(cap2),
      .cap_flag(cap_flag), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(negedge clk) cnt_val <= cnt_val + 1;

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: pin samples held in a queue, capture count drives acceptance
   bit           hist[$];
   logic [W-1:0] m_c1, m_c2;
   bit           m_flag;
   int           m_taken;

   always @(posedge clk) begin
      if (rst) begin
         hist = '{0, 0, 0};
         m_c1 = '0; m_c2 = '0; m_flag = 0; m_taken = 0;
      end else begin
         bit now_s, old_s, hit_m;
         now_s = hist[1];
         old_s = hist[2];
         hit_m = (edge_sel[0] && now_s && !old_s) || (edge_sel[1] && !now_s && old_s);
         if (stat_clr) begin
            if (m_flag) begin
               m_flag = 0;
               m_taken = 0;
            end
         end else if (hit_m) begin
            if (m_taken == 0) begin
               m_c1 = cnt_val; m_flag = 1; m_taken = 1;
            end else if (m_taken == 1 && dual_mode) begin
               m_c2 = cnt_val; m_taken = 2;
            end
         end
         hist.push_front(evt_pin);
         void'(hist.pop_back());
      end
   end

   always @(negedge clk) begin
      if (!rst && !finished) begin
         #1;
         chk("R2 R4 cap1 vs model", cap1, m_c1);
         chk("R5 cap2 vs model", cap2, m_c2);
         chk("R3 flag vs model", {31'd0, cap_flag}, {31'd0, m_flag});
         chk("R9 irq vs model", {31'd0, irq}, {31'd0, m_flag & irq_en});
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // set pin at a falling edge, return counter value expected at capture edge
   task automatic set_pin(bit v, output logic [W-1:0] exp_cnt);
      @(negedge clk);
      evt_pin = v;
      #1;
      exp_cnt = cnt_val + 2;
   endtask

   task automatic clear_flag();
      @(negedge clk);
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finished = 1;
      summary();
   end

   initial begin
      logic [W-1:0] e1, e2, keep;
      cyc(4);
      #1;
      chk("R10 reset cap1", cap1, '0);
      chk("R10 reset flag", {31'd0, cap_flag}, 32'd0);
      rst = 1'b0;
      cyc(3);

      // R1 none selected
      edge_sel = 2'd0;
      set_pin(1, e1); cyc(3); set_pin(0, e1); cyc(4);
      chk("R1 none selected no flag", {31'd0, cap_flag}, 32'd0);

      // single mode, rising
      edge_sel = 2'd1; irq_en = 1'b1; dual_mode = 1'b0;
      set_pin(1, e1); cyc(4);
      chk("R2 first rise latency", cap1, e1);
      chk("R9 irq level", {31'd0, irq}, 32'd1);
      set_pin(0, e2); cyc(3); set_pin(1, e2); cyc(4);
      chk("R4 later rise ignored", cap1, e1);
      irq_en = 1'b0; cyc(1); #1;
      chk("R9 irq masked", {31'd0, irq}, 32'd0);

      // re-arm
      clear_flag(); #1;
      chk("R6 flag cleared", {31'd0, cap_flag}, 32'd0);
      keep = cap1;
      clear_flag(); #1;
      chk("R7 clear on idle keeps cap1", cap1, keep);
      set_pin(0, e2); cyc(3); set_pin(1, e2); cyc(4);
      chk("R6 capture after re-arm", cap1, e2);

      // dual mode rising
      clear_flag(); dual_mode = 1'b1; irq_en = 1'b1;
      set_pin(0, e1); cyc(3);
      set_pin(1, e1); cyc(3); set_pin(0, e2); cyc(3); set_pin(1, e2); cyc(4);
      chk("R5 dual first", cap1, e1);
      chk("R5 dual second", cap2, e2);
      keep = cap2;
      set_pin(0, e1); cyc(3); set_pin(1, e1); cyc(4);
      chk("R5 third ignored", cap2, keep);

      // one-cycle pulse, both edges
      clear_flag(); edge_sel = 2'd3;
      set_pin(0, e1); cyc(4);
      clear_flag();
      @(negedge clk); evt_pin = 1'b1;
      @(negedge clk); evt_pin = 1'b0;
      cyc(4); #1;
      chk("R11 pulse width diff", cap2 - cap1, 32'd1);

      // falling only
      clear_flag(); edge_sel = 2'd2; dual_mode = 1'b0;
      set_pin(1, e1); cyc(4);
      chk("R1 rise ignored under fall select", {31'd0, cap_flag}, 32'd0);
      set_pin(0, e2); cyc(4);
      chk("R1 fall captured", cap1, e2);

      // clear coinciding with capture edge, flag set
      edge_sel = 2'd1; keep = cap1;
      @(negedge clk); evt_pin = 1'b1;
      @(negedge clk);
      @(negedge clk); stat_clr = 1'b1;
      @(negedge clk); stat_clr = 1'b0; #1;
      chk("R8 coincident event dropped flag", {31'd0, cap_flag}, 32'd0);
      chk("R8 coincident event dropped cap1", cap1, keep);

      // clear coinciding with capture edge, flag clear
      set_pin(0, e1); cyc(3);
      @(negedge clk); evt_pin = 1'b1;
      @(negedge clk);
      @(negedge clk); stat_clr = 1'b1;
      @(negedge clk); stat_clr = 1'b0; #1;
      chk("R8 dropped with idle flag", cap1, keep);
      chk("R7 idle clear flag", {31'd0, cap_flag}, 32'd0);

      // reset while locked
      set_pin(0, e1); cyc(3); set_pin(1, e1); cyc(4);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); #1;
      chk("R10 reset clears cap1", cap1, '0);
      chk("R10 reset clears flag", {31'd0, cap_flag}, 32'd0);
      chk("R10 reset clears irq", {31'd0, irq}, 32'd0);
      rst = 1'b0;
      cyc(3);

      finished = 1;
      summary();
   end

endmodule